// File: doc/BRIEF.md
# Double-Buffered BCD Real-Time Clock

This block keeps calendar time as packed BCD counters (seconds, minutes, hours in 24-hour form, day of week, day of month, month, two-digit year). A one-pulse-per-second input advances the counters. Software never touches these counters directly. It sees a second, user-visible copy of the fields plus a control byte, placed in the eight highest addresses of a 128K x 8 byte bus. Addresses below that window belong to a storage array outside this block, and the block neither drives data for them nor stores writes to them.

The control byte has two bits. A hold bit freezes the visible copy so that software can read a coherent snapshot while the hidden count keeps running. A set bit opens the visible fields to bus writes, and clearing it transfers all seven fields into the hidden counters at once. With neither bit set, the visible copy is refreshed as a whole on the cycle after each tick. A power-fail input makes the block ignore all bus traffic.

Top module: `rtc_dbuf`

## Requirements
- R1: The window is addresses 0x1FFF8 to 0x1FFFF. 0x1FFF8 is control, with bit 7 the set bit and bit 6 the hold bit. Bits 5..0 read as 0. Then come seconds (+1), minutes (+2), hours (+3), day of week (+4), date (+5), month (+6) and year (+7). Reads of lower addresses return 0x00 and writes there change nothing visible. Read data is 0x00 unless chip select and output enable are both high.
- R2: After reset, control reads 0x00 and the time reads 00:00:00, day 01, date 01, month 01, year 00.
- R3: Seconds and minutes count 00..59 and hours 00..23 in BCD (09 steps to 10). Each wrap carries into the next field, and the hours wrap carries into both day of week and date.
- R4: Day of week counts 01..07 and wraps to 01.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Each wrap carries into the month.
- R6: February ends at 29 when the year is divisible by four and at 28 otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R7: With both control bits 0, the visible fields change on the second clock edge after the edge that samples a tick, never on that first edge.
- R8: While the hold bit is 1 and the set bit is 0, the visible fields keep their value whatever ticks arrive. The hidden count keeps advancing.
- R9: After a control write clears the hold bit, every visible field shows the hidden count one clock edge later.
- R10: Field writes land in the visible copy only while the set bit is 1. With the set bit 0 they are ignored.
- R11: A control write that clears the set bit loads all seven visible fields into the hidden counters on that edge. A tick sampled on the same edge is discarded.
- R12: While power-fail is high, reads return 0x00 and writes, including control writes, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| pwr_fail | input | 1 | High while the supply is out of tolerance |
| bus_addr | input | 17 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_cs | input | 1 | Chip select, active high |
| bus_we | input | 1 | Write enable, active high |
| bus_oe | input | 1 | Output enable, active high |
| bus_rdata | output | 8 | Read data, 0x00 when not selected |

## Verification
The counting chain is driven from chosen start times that each aim at one carry path. These are a lone BCD digit carry, the full 23:59:59 cascade, a day-of-week wrap, and date rollovers at 29, 30 and 31 days in both leap and common years up to the year wrap. Each of them tells apart a different missing or wrong carry. The buffer behaviour is tried with ticks during a hold, a release followed by an immediate read, a tick sampled on the load edge, and writes with the set bit off or power failing. Together these separate a frozen display from a stopped count, a late refresh from a timely one, and a guarded write path from an open one.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
// rtc_pkg: shared time record and BCD helpers for the double-buffered clock.
// Assumes all field values are packed BCD; no range checks on loaded data.
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hours;
        logic [7:0] mins;
        logic [7:0] secs;
    } rtc_time_t;

    localparam rtc_time_t RST_TIME = '{year: 8'h00, month: 8'h01, mday: 8'h01,
                                       wday: 8'h01, hours: 8'h00, mins: 8'h00,
                                       secs: 8'h00};

    // One BCD step with wrap: returns {wrapped, next value}.
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v == last)
            return {1'b1, first};
        else if (v[3:0] == 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last date of a month (BCD), leap when the two-digit year divides by four.
    function automatic logic [7:0] month_end(input logic [7:0] month,
                                             input logic [7:0] year);
        logic [7:0] ybin;
        ybin = {4'd0, year[7:4]} * 8'd10 + {4'd0, year[3:0]};
        case (month)
            8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_core.sv
`timescale 1ns/1ps
// rtc_time_core: hidden calendar counters. Advances once per tick through the
// full BCD carry chain; a load replaces every field at once and wins over tick.
// Assumes tick is a single-cycle pulse.
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now
);

    rtc_time_t nxt;
    logic c_s, c_m, c_h, c_d, c_mo, c_unused_w, c_unused_y;

    // Next-second value: ripple of carries from seconds up to year.
    always_comb begin
        nxt = now;
        {c_s, nxt.secs} = bcd_step(now.secs, 8'h59, 8'h00);
        c_m = 1'b0; c_h = 1'b0; c_d = 1'b0; c_mo = 1'b0;
        c_unused_w = 1'b0; c_unused_y = 1'b0;
        if (c_s)  {c_m, nxt.mins}  = bcd_step(now.mins, 8'h59, 8'h00);
        if (c_m)  {c_h, nxt.hours} = bcd_step(now.hours, 8'h23, 8'h00);
        if (c_h)  {c_unused_w, nxt.wday} = bcd_step(now.wday, 8'h07, 8'h01);
        if (c_h)  {c_d, nxt.mday}  = bcd_step(now.mday, month_end(now.month, now.year), 8'h01);
        if (c_d)  {c_mo, nxt.month} = bcd_step(now.month, 8'h12, 8'h01);
        if (c_mo) {c_unused_y, nxt.year} = bcd_step(now.year, 8'h99, 8'h00);
    end

    // Counter register: reset, bulk load, or one-second advance.
    always_ff @(posedge clk) begin
        if (!rst_n)     now <= RST_TIME;
        else if (load)  now <= load_val;
        else if (tick)  now <= nxt;
    end

endmodule

// File: rtl/rtc_bus_regs.sv
`timescale 1ns/1ps
// rtc_bus_regs: user-visible field bank, control byte and bus decode for the
// top eight byte addresses. Refreshes the bank whole from the hidden count one
// cycle after a tick or control write, unless hold or set is active.
// Assumes single-cycle write strobes and combinational reads.
module rtc_bus_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pwr_fail,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              cs,
    input  logic              we,
    input  logic              oe,
    input  rtc_time_t         now,
    output logic [7:0]        rdata,
    output logic              load,
    output rtc_time_t         shown,
    output logic              hold_q,
    output logic              set_q
);

    localparam int FIELDS = 7;
    localparam logic [FIELDS:1][7:0] RST_ARR = RST_TIME;

    logic [FIELDS:1][7:0] vis_q;
    logic [FIELDS:1][7:0] now_arr;
    logic [2:0]           idx;
    logic                 hit, acc, wr_stb, ctl_wr, refresh_q, copy;

    assign idx     = addr[2:0];
    assign hit     = &addr[ADDR_W-1:3];
    assign acc     = cs && !pwr_fail && hit;
    assign wr_stb  = acc && we;
    assign ctl_wr  = wr_stb && (idx == 3'd0);
    assign load    = ctl_wr && set_q && !wdata[7];
    assign copy    = refresh_q && !hold_q && !set_q;
    assign now_arr = now;
    assign shown   = rtc_time_t'(vis_q);

    // Control byte: hold and set bits written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      {set_q, hold_q} <= 2'b00;
        else if (ctl_wr) {set_q, hold_q} <= wdata[7:6];
    end

    // Refresh request raised by a tick or any control write.
    always_ff @(posedge clk) begin
        if (!rst_n) refresh_q <= 1'b0;
        else        refresh_q <= tick || ctl_wr;
    end

    // One register per visible field: bus write while set, else bulk refresh.
    for (genvar i = 1; i <= FIELDS; i++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n)                                      vis_q[i] <= RST_ARR[i];
            else if (wr_stb && set_q && idx == 3'(i))        vis_q[i] <= wdata;
            else if (copy)                                   vis_q[i] <= now_arr[i];
        end
    end

    // Read mux: control byte or a visible field, zero when not selected.
    always_comb begin
        rdata = 8'h00;
        if (acc && oe) begin
            if (idx == 3'd0) rdata = {set_q, hold_q, 6'd0};
            else             rdata = vis_q[idx];
        end
    end

endmodule

// File: rtl/rtc_dbuf.sv
`timescale 1ns/1ps
// rtc_dbuf: top of the double-buffered BCD clock. Joins the hidden counters
// to the visible register bank. Assumes tick_1hz is synchronous to clk.
module rtc_dbuf
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              pwr_fail,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic              bus_oe,
    output logic [7:0]        bus_rdata
);

    rtc_time_t now, shown;
    logic      load, hold_q, set_q;

    rtc_time_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .load     (load),
        .load_val (shown),
        .now      (now)
    );

    rtc_bus_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .pwr_fail (pwr_fail),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cs       (bus_cs),
        .we       (bus_we),
        .oe       (bus_oe),
        .now      (now),
        .rdata    (bus_rdata),
        .load     (load),
        .shown    (shown),
        .hold_q   (hold_q),
        .set_q    (set_q)
    );

endmodule

// File: rtl/rtc_dbuf_chk.sv
`timescale 1ns/1ps
// rtc_dbuf_chk: temporal checks on the double-buffered clock, bound to rtc_dbuf.
module rtc_dbuf_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_fail,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              hold_q,
    input logic              set_q,
    input logic [55:0]       shown,
    input logic [55:0]       now
);

    localparam logic [ADDR_W-1:0] WIN_BASE = {{(ADDR_W-3){1'b1}}, 3'b000};

    // R12: no read data while power is failing.
    a_r12_pf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |-> bus_rdata == 8'h00);

    // R12: a failing supply blocks control writes.
    a_r12_pf_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_fail) |-> ($stable(hold_q) && $stable(set_q)));

    // R1: nothing is driven for addresses below the window.
    a_r1_low_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < WIN_BASE) |-> bus_rdata == 8'h00);

    // R8: holding freezes the visible bank.
    a_r8_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold_q && !set_q) |-> $stable(shown));

    // R11: clearing the set bit moves the visible bank into the counters.
    a_r11_bulk_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(set_q) |-> now == $past(shown));

endmodule

bind rtc_dbuf rtc_dbuf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_fail  (pwr_fail),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .hold_q    (hold_q),
    .set_q     (set_q),
    .shown     (shown),
    .now       (now)
);

// File: tb/tb_rtc_dbuf.sv
`timescale 1ns/1ps
// tb_rtc_dbuf: directed scenarios, one task each, self-checking.
module tb_rtc_dbuf;

    localparam logic [16:0] BASE = 17'h1FFF8;

    logic        clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, pwr_fail = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0, bus_rdata;
    logic        bus_cs = 1'b0, bus_we = 1'b0, bus_oe = 1'b0;
    int          n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    rtc_dbuf dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_fail(pwr_fail),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cs(bus_cs),
        .bus_we(bus_we), .bus_oe(bus_oe), .bus_rdata(bus_rdata)
    );

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_cs = 1'b1; bus_we = 1'b1;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [16:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] got;
        bus_addr = a; bus_cs = 1'b1; bus_oe = 1'b1;
        #0.5 got = bus_rdata;
        bus_cs = 1'b0; bus_oe = 1'b0;
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, a, got, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, wd, dt, mo, y);
        wr(BASE, 8'h80);
        wr(BASE + 1, s);  wr(BASE + 2, mi); wr(BASE + 3, h);  wr(BASE + 4, wd);
        wr(BASE + 5, dt); wr(BASE + 6, mo); wr(BASE + 7, y);
        wr(BASE, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk(BASE,     8'h00, "R2 ctrl");
        rd_chk(BASE + 1, 8'h00, "R2 sec");
        rd_chk(BASE + 2, 8'h00, "R2 min");
        rd_chk(BASE + 3, 8'h00, "R2 hour");
        rd_chk(BASE + 4, 8'h01, "R2 wday");
        rd_chk(BASE + 5, 8'h01, "R2 date");
        rd_chk(BASE + 6, 8'h01, "R2 month");
        rd_chk(BASE + 7, 8'h00, "R2 year");
    endtask

    task automatic t_decode();
        wr(BASE, 8'h7F);
        rd_chk(BASE, 8'h40, "R1 ctrl bits");
        wr(BASE, 8'h00);
        @(negedge clk);
        bus_addr = BASE + 4; bus_cs = 1'b1; bus_oe = 1'b0;
        #0.5 n_chk++;
        if (bus_rdata !== 8'h00) begin
            n_bad++; $display("FAIL R1 oe low got=%h exp=00", bus_rdata);
        end
        bus_cs = 1'b0;
        wr(17'h00010, 8'h5A);
        rd_chk(17'h00010, 8'h00, "R1 low addr");
        wr(BASE - 1, 8'h33);
        rd_chk(BASE - 1, 8'h00, "R1 below window");
    endtask

    task automatic t_guard();
        wr(BASE + 1, 8'h45);
        rd_chk(BASE + 1, 8'h00, "R10 write ignored");
        wr(BASE, 8'h80);
        wr(BASE + 1, 8'h12);
        rd_chk(BASE + 1, 8'h12, "R10 write lands");
        wr(BASE, 8'h00);
        @(negedge clk);
    endtask

    task automatic t_carry();
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h15, 8'h06, 8'h21);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        rd_chk(BASE + 1, 8'h59, "R7 not yet");
        @(negedge clk);
        rd_chk(BASE + 1, 8'h00, "R7 sec");
        rd_chk(BASE + 2, 8'h00, "R3 min");
        rd_chk(BASE + 3, 8'h00, "R3 hour");
        rd_chk(BASE + 4, 8'h04, "R3 wday");
        rd_chk(BASE + 5, 8'h16, "R3 date");
        rd_chk(BASE + 6, 8'h06, "R3 month");
        set_time(8'h09, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        pulse_tick();
        rd_chk(BASE + 1, 8'h10, "R3 bcd digit");
    endtask

    task automatic t_wday();
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h03, 8'h22);
        pulse_tick();
        rd_chk(BASE + 4, 8'h01, "R4 wday wrap");
    endtask

    task automatic roll(input logic [7:0] dt, mo, y, edt, emo, ey, input string tag);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, dt, mo, y);
        pulse_tick();
        rd_chk(BASE + 5, edt, tag);
        rd_chk(BASE + 6, emo, tag);
        rd_chk(BASE + 7, ey,  tag);
    endtask

    task automatic t_months();
        roll(8'h30, 8'h04, 8'h21, 8'h01, 8'h05, 8'h21, "R5 30-day");
        roll(8'h29, 8'h06, 8'h21, 8'h30, 8'h06, 8'h21, "R5 no wrap");
        roll(8'h31, 8'h01, 8'h21, 8'h01, 8'h02, 8'h21, "R5 31-day");
        roll(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23, "R6 common Feb");
        roll(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24, "R6 leap 28");
        roll(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24, "R6 leap 29");
        roll(8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00, "R6 year wrap");
    endtask

    task automatic t_hold();
        set_time(8'h30, 8'h20, 8'h10, 8'h02, 8'h05, 8'h05, 8'h20);
        wr(BASE, 8'h40);
        for (int i = 0; i < 3; i++) pulse_tick();
        rd_chk(BASE + 1, 8'h30, "R8 frozen sec");
        rd_chk(BASE + 2, 8'h20, "R8 frozen min");
        wr(BASE, 8'h00);
        @(negedge clk);
        rd_chk(BASE + 1, 8'h33, "R9 sec refreshed");
        rd_chk(BASE + 2, 8'h20, "R9 min");
        rd_chk(BASE + 3, 8'h10, "R9 hour");
    endtask

    task automatic t_load_tick();
        wr(BASE, 8'h80);
        wr(BASE + 1, 8'h05);
        @(negedge clk);
        bus_addr = BASE; bus_wdata = 8'h00; bus_cs = 1'b1; bus_we = 1'b1; tick_1hz = 1'b1;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0; tick_1hz = 1'b0;
        @(negedge clk);
        rd_chk(BASE + 1, 8'h05, "R11 tick dropped");
        pulse_tick();
        rd_chk(BASE + 1, 8'h06, "R11 counts on");
    endtask

    task automatic t_pwr();
        @(negedge clk); pwr_fail = 1'b1;
        rd_chk(BASE + 1, 8'h00, "R12 read blocked");
        wr(BASE, 8'h80);
        wr(BASE + 1, 8'h44);
        @(negedge clk); pwr_fail = 1'b0;
        rd_chk(BASE, 8'h00, "R12 ctrl kept");
        rd_chk(BASE + 1, 8'h06, "R12 field kept");
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_guard();
        t_carry();
        t_wday();
        t_months();
        t_hold();
        t_load_tick();
        t_pwr();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule